// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block decides which microword a microcoded controller fetches next. The controller keeps 4096 microwords of 36 bits each. Every cycle the block receives the word stored at its current microaddress, which the control store returns combinationally. It then selects the following microaddress. The choices are the incremented address, a 12-bit jump target (taken always or only when one of four condition inputs is set), or a return address from a small subroutine stack. The stack holds return points for nested calls, and the jump-with-pop variant lets microcode drop a return point it no longer needs.

Every fetched word carries an even-parity bit. A word that fails the parity check is not executed. The sequencer raises a sticky error and freezes the microaddress until reset. A two-bit trap-control field in each valid word sets, clears or keeps a trap-enable flag, which leaves the block as an output.

Top module: `useq_next_addr`

## Requirements
- R1: While reset is high, at the following clock edge the microaddress becomes 0, the parity error output and the trap enable output go low, and the subroutine stack becomes empty.
- R2: Microword fields: bits [11:0] are the jump target, [14:12] the jump-control code, bit 15 the return-select bit, [17:16] the trap control, and bit 35 the parity bit, chosen so that the 36-bit word has an even number of ones. Bits [34:18] are ignored.
- R3: Jump-control 000 advances to the current microaddress plus one, and 4095 wraps to 0.
- R4: Jump-control codes 001, 010, 011 and 100 test cond_i[0], cond_i[1], cond_i[2] and cond_i[3] respectively. When the tested bit is 1 the next address is the jump target, otherwise it is the current address plus one.
- R5: Jump-control 111 always loads the jump target.
- R6: Jump-control 101 is a call. It pushes the current address plus one onto the stack and loads the jump target.
- R7: Jump-control 110 loads the jump target and discards the top stack entry.
- R8: When the return-select bit is 1, the next address is the top stack entry, which is then popped. The jump-control field is ignored in that cycle.
- R9: The stack holds 4 entries. A push onto a full stack discards the oldest entry. A return from an empty stack yields address 0.
- R10: Trap control 00 keeps the trap enable, 01 clears it, and 10 or 11 sets it. The new value is visible after the clock edge.
- R11: A word with odd parity has no effect on the address, the stack or the trap enable. After that edge the parity error output is 1 and stays 1 until reset, and the microaddress and trap enable stay frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| uword_i | input | 36 | Microword fetched at uaddr_o |
| cond_i | input | 4 | Condition inputs for conditional jumps |
| uaddr_o | output | 12 | Current microaddress |
| parity_err_o | output | 1 | Sticky parity error flag |
| trap_en_o | output | 1 | Trap enable flag |

## Verification
The stack is the only state the ports cannot show directly. A wrong entry, a lost entry or a bad overflow rule appears at uaddr_o on the first return that reaches it. For that reason the bench drives call chains deeper than four entries and then unwinds them one return at a time, past the empty point. A wrong increment, branch or trap decision shows one edge after the offending word. A broken parity freeze shows within a cycle as an address that moves while the error flag is high.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int UADDR_W   = 12;
    localparam int UWORD_W   = 36;
    localparam int COND_W    = 4;
    localparam int STK_DEPTH = 4;

    typedef logic [UADDR_W-1:0] uaddr_t;

    typedef enum logic [2:0] {
        JC_SEQ  = 3'b000,
        JC_CND0 = 3'b001,
        JC_CND1 = 3'b010,
        JC_CND2 = 3'b011,
        JC_CND3 = 3'b100,
        JC_CALL = 3'b101,
        JC_JPOP = 3'b110,
        JC_JMP  = 3'b111
    } jc_e;

    typedef enum logic [1:0] {
        TRAP_KEEP = 2'b00,
        TRAP_OFF  = 2'b01,
        TRAP_ON0  = 2'b10,
        TRAP_ON1  = 2'b11
    } trap_e;

    typedef struct packed {
        logic        par;
        logic [16:0] spare;
        trap_e       trap;
        logic        ret_src;
        jc_e         jc;
        uaddr_t      jaddr;
    } uword_t;

    typedef struct packed {
        logic   push;
        logic   pop;
        uaddr_t push_val;
    } stk_op_t;

    function automatic logic [1:0] cond_index(jc_e code);
        logic [2:0] raw;
        raw = 3'(code) - 3'd1;
        return raw[1:0];
    endfunction

endpackage

// File: rtl/useq_parity_chk.sv
module useq_parity_chk
    import useq_pkg::*;
(
    input  uword_t word_i,
    output logic   ok_o
);
    localparam int W = $bits(uword_t);
    logic [W-1:0] flat;

    assign flat = word_i;
    assign ok_o = ~(^flat);
endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack
    import useq_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH
) (
    input  logic    clk,
    input  logic    rst,
    input  stk_op_t op_i,
    output uaddr_t  top_o
);
    uaddr_t ent_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            uaddr_t below, above;
            if (i == 0) begin : g_top
                assign above = op_i.push_val;
            end else begin : g_mid
                assign above = ent_q[i-1];
            end
            if (i == DEPTH - 1) begin : g_bot
                assign below = '0;
            end else begin : g_inner
                assign below = ent_q[i+1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q[i] <= '0;
                end else if (op_i.push && op_i.pop) begin
                    if (i == 0) ent_q[i] <= op_i.push_val;
                end else if (op_i.push) begin
                    ent_q[i] <= above;
                end else if (op_i.pop) begin
                    ent_q[i] <= below;
                end
            end
        end
    endgenerate

    assign top_o = ent_q[0];
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
    import useq_pkg::*;
(
    input  jc_e                jc_i,
    input  logic               ret_src_i,
    input  uaddr_t             jaddr_i,
    input  logic [COND_W-1:0]  cond_i,
    input  uaddr_t             cur_i,
    input  uaddr_t             stk_top_i,
    output uaddr_t             nxt_o,
    output stk_op_t            op_o
);
    uaddr_t inc;

    assign inc = cur_i + UADDR_W'(1);

    always_comb begin
        op_o          = '0;
        op_o.push_val = inc;
        nxt_o         = inc;
        if (ret_src_i) begin
            nxt_o     = stk_top_i;
            op_o.pop  = 1'b1;
        end else begin
            unique case (jc_i)
                JC_SEQ:  nxt_o = inc;
                JC_CALL: begin
                    nxt_o     = jaddr_i;
                    op_o.push = 1'b1;
                end
                JC_JPOP: begin
                    nxt_o    = jaddr_i;
                    op_o.pop = 1'b1;
                end
                JC_JMP:  nxt_o = jaddr_i;
                default: nxt_o = cond_i[cond_index(jc_i)] ? jaddr_i : inc;
            endcase
        end
    end
endmodule

// File: rtl/useq_trap_reg.sv
module useq_trap_reg
    import useq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  trap_e ctl_i,
    output logic  trap_en_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            trap_en_o <= 1'b0;
        end else if (en_i) begin
            unique case (ctl_i)
                TRAP_KEEP:          trap_en_o <= trap_en_o;
                TRAP_OFF:           trap_en_o <= 1'b0;
                TRAP_ON0, TRAP_ON1: trap_en_o <= 1'b1;
                default:            trap_en_o <= trap_en_o;
            endcase
        end
    end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
    import useq_pkg::*;
#(
    parameter int DEPTH = STK_DEPTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [UWORD_W-1:0] uword_i,
    input  logic [COND_W-1:0]  cond_i,
    output logic [UADDR_W-1:0] uaddr_o,
    output logic               parity_err_o,
    output logic               trap_en_o
);
    uword_t  w;
    logic    par_ok;
    logic    exec;
    uaddr_t  addr_q;
    uaddr_t  nxt;
    uaddr_t  stk_top;
    stk_op_t op_raw;
    stk_op_t op_gated;
    logic    err_q;

    assign w = uword_t'(uword_i);

    useq_parity_chk u_par (
        .word_i (w),
        .ok_o   (par_ok)
    );

    assign exec = par_ok && !err_q;

    useq_next_sel u_sel (
        .jc_i      (w.jc),
        .ret_src_i (w.ret_src),
        .jaddr_i   (w.jaddr),
        .cond_i    (cond_i),
        .cur_i     (addr_q),
        .stk_top_i (stk_top),
        .nxt_o     (nxt),
        .op_o      (op_raw)
    );

    always_comb begin
        op_gated      = op_raw;
        op_gated.push = op_raw.push && exec;
        op_gated.pop  = op_raw.pop && exec;
    end

    useq_ret_stack #(.DEPTH(DEPTH)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op_gated),
        .top_o (stk_top)
    );

    useq_trap_reg u_trap (
        .clk       (clk),
        .rst       (rst),
        .en_i      (exec),
        .ctl_i     (w.trap),
        .trap_en_o (trap_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (exec) addr_q <= nxt;
            if (!par_ok) err_q <= 1'b1;
        end
    end

    assign uaddr_o      = addr_q;
    assign parity_err_o = err_q;
endmodule

// File: rtl/useq_chk.sv
module useq_chk (
    input logic        clk,
    input logic        rst,
    input logic [35:0] uword_i,
    input logic [11:0] uaddr_o,
    input logic        parity_err_o,
    input logic        trap_en_o
);
    logic good;
    assign good = !parity_err_o && !(^uword_i);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (uaddr_o == 12'd0) && !parity_err_o && !trap_en_o);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        parity_err_o |=> parity_err_o);

    // R11
    err_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        parity_err_o |=> $stable(uaddr_o) && $stable(trap_en_o));

    // R11
    bad_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!parity_err_o && (^uword_i)) |=> parity_err_o && $stable(uaddr_o) && $stable(trap_en_o));

    // R3
    seq_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (good && !uword_i[15] && uword_i[14:12] == 3'b000)
        |=> uaddr_o == 12'($past(uaddr_o) + 12'd1));

    // R5
    jmp_target_chk: assert property (@(posedge clk) disable iff (rst)
        (good && !uword_i[15] && uword_i[14:12] == 3'b111)
        |=> uaddr_o == $past(uword_i[11:0]));

    // R6
    call_target_chk: assert property (@(posedge clk) disable iff (rst)
        (good && !uword_i[15] && uword_i[14:12] == 3'b101)
        |=> uaddr_o == $past(uword_i[11:0]));

    // R10
    trap_off_chk: assert property (@(posedge clk) disable iff (rst)
        (good && uword_i[17:16] == 2'b01) |=> !trap_en_o);

    // R10
    trap_on_chk: assert property (@(posedge clk) disable iff (rst)
        (good && uword_i[17]) |=> trap_en_o);

    // R10
    trap_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (good && uword_i[17:16] == 2'b00) |=> $stable(trap_en_o));
endmodule

bind useq_next_addr useq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .uword_i      (uword_i),
    .uaddr_o      (uaddr_o),
    .parity_err_o (parity_err_o),
    .trap_en_o    (trap_en_o)
);

// File: tb/useq_next_addr_tb_top.sv
`timescale 1ns/1ps
module useq_next_addr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [35:0] uword_i = '0;
    logic [3:0]  cond_i = '0;
    logic [11:0] uaddr_o;
    logic        parity_err_o;
    logic        trap_en_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    logic [11:0] m_addr;
    logic        m_err;
    logic        m_trap;
    logic [11:0] m_stk[$];

    always #2 clk = ~clk;

    useq_next_addr dut_i (
        .clk          (clk),
        .rst          (rst),
        .uword_i      (uword_i),
        .cond_i       (cond_i),
        .uaddr_o      (uaddr_o),
        .parity_err_o (parity_err_o),
        .trap_en_o    (trap_en_o)
    );

    function automatic logic [35:0] mk(logic [2:0] jc, logic src, logic [1:0] tr,
                                       logic [11:0] ja, logic bad);
        logic [35:0] w;
        w = '0;
        w[11:0]  = ja;
        w[14:12] = jc;
        w[15]    = src;
        w[17:16] = tr;
        w[35]    = (^w[34:0]) ^ bad;
        return w;
    endfunction

    function automatic logic [11:0] m_pop();
        if (m_stk.size() == 0) return 12'd0;
        return m_stk.pop_front();
    endfunction

    task automatic model_reset();
        m_addr = '0; m_err = 0; m_trap = 0; m_stk.delete();
    endtask

    task automatic model_step(input logic [35:0] w, input logic [3:0] c);
        logic [11:0] inc, nxt;
        logic [2:0]  jc;
        if (m_err) return;
        if (^w) begin
            m_err = 1;
            return;
        end
        inc = m_addr + 12'd1;
        jc  = w[14:12];
        if (w[15]) begin
            nxt = m_pop();
        end else if (jc == 3'd0) begin
            nxt = inc;
        end else if (jc <= 3'd4) begin
            nxt = c[jc - 3'd1] ? w[11:0] : inc;
        end else if (jc == 3'd5) begin
            m_stk.push_front(inc);
            if (m_stk.size() > 4) void'(m_stk.pop_back());
            nxt = w[11:0];
        end else if (jc == 3'd6) begin
            void'(m_pop());
            nxt = w[11:0];
        end else begin
            nxt = w[11:0];
        end
        if (w[17]) m_trap = 1;
        else if (w[16]) m_trap = 0;
        m_addr = nxt;
    endtask

    task automatic check(input string req);
        n_chk += 3;
        if (uaddr_o !== m_addr) begin
            n_fail++;
            $display("FAIL %s uaddr actual=%0d expected=%0d", req, uaddr_o, m_addr);
        end
        if (parity_err_o !== m_err) begin
            n_fail++;
            $display("FAIL %s parity_err actual=%0b expected=%0b", req, parity_err_o, m_err);
        end
        if (trap_en_o !== m_trap) begin
            n_fail++;
            $display("FAIL %s trap_en actual=%0b expected=%0b", req, trap_en_o, m_trap);
        end
    endtask

    task automatic cyc(input logic [35:0] w, input logic [3:0] c, input string req);
        uword_i = w;
        cond_i  = c;
        model_step(w, c);
        @(negedge clk);
        check(req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        uword_i = '0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1");
        rst = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: outputs after reset, then empty-stack return gives 0 (R9)
        do_reset();
        cyc(mk(3'd0, 0, 2'b00, 12'd0, 0), 4'h0, "R3");
        cyc(mk(3'd7, 1, 2'b00, 12'd77, 0), 4'h0, "R9");
        // R5 and wrap (R3); spare bits set (R2)
        cyc(mk(3'd7, 0, 2'b00, 12'd4095, 0) | (36'h3 << 20), 4'h0, "R5");
        cyc(mk(3'd0, 0, 2'b00, 12'd9, 0), 4'h0, "R3");
        // R4: each condition taken and not taken
        for (int n = 1; n <= 4; n++) begin
            cyc(mk(3'(n), 0, 2'b00, 12'(100 * n), 0), 4'(1 << (n - 1)), "R4");
            cyc(mk(3'(n), 0, 2'b00, 12'(100 * n + 7), 0), ~4'(1 << (n - 1)), "R4");
        end
        // R6, R9: five nested calls, then six returns
        for (int k = 0; k < 5; k++)
            cyc(mk(3'd5, 0, 2'b00, 12'(1000 + 10 * k), 0), 4'h0, "R6");
        for (int k = 0; k < 6; k++)
            cyc(mk(3'd0, 1, 2'b00, 12'd5, 0), 4'h0, "R9");
        // R7: call, call, jump-with-pop, return
        cyc(mk(3'd5, 0, 2'b00, 12'd200, 0), 4'h0, "R6");
        cyc(mk(3'd5, 0, 2'b00, 12'd300, 0), 4'h0, "R6");
        cyc(mk(3'd6, 0, 2'b00, 12'd400, 0), 4'h0, "R7");
        cyc(mk(3'd0, 1, 2'b00, 12'd0, 0), 4'h0, "R7");
        // R8: return overrides a jump code
        cyc(mk(3'd5, 0, 2'b00, 12'd600, 0), 4'h0, "R6");
        cyc(mk(3'd7, 1, 2'b00, 12'd999, 0), 4'h0, "R8");
        // R10: trap control codes
        cyc(mk(3'd0, 0, 2'b10, 12'd0, 0), 4'h0, "R10");
        cyc(mk(3'd0, 0, 2'b00, 12'd0, 0), 4'h0, "R10");
        cyc(mk(3'd0, 0, 2'b01, 12'd0, 0), 4'h0, "R10");
        cyc(mk(3'd0, 0, 2'b11, 12'd0, 0), 4'h0, "R10");
        // random mix of all codes
        for (int k = 0; k < 3000; k++) begin
            logic [35:0] w;
            w = mk(3'($urandom_range(0, 7)), ($urandom_range(0, 7) == 0),
                   2'($urandom_range(0, 3)), 12'($urandom), 0);
            w[34:18] = 17'($urandom);
            w[35] = ^w[34:0];
            cyc(w, 4'($urandom), "R2");
        end
        // R11: bad word has no effect, error sticks and freezes
        cyc(mk(3'd5, 0, 2'b00, 12'd700, 0), 4'h0, "R6");
        cyc(mk(3'd5, 0, 2'b01, 12'd123, 1), 4'h0, "R11");
        cyc(mk(3'd7, 0, 2'b10, 12'd55, 0), 4'hF, "R11");
        cyc(mk(3'd0, 1, 2'b11, 12'd0, 0), 4'hF, "R11");
        cyc(mk(3'd0, 0, 2'b00, 12'd0, 0), 4'h0, "R11");
        // R1 again: reset clears the error and empties the stack
        do_reset();
        cyc(mk(3'd0, 1, 2'b00, 12'd0, 0), 4'h0, "R1");
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule